// File: doc/BRIEF.md
# Instruction Byte Collector and Operand Addresser

This block sits behind an instruction fetch path. It takes in an 8-bit instruction stream, one byte per accepted transfer, and groups the bytes into instructions of one, two or three bytes. The first byte of each instruction is always the opcode. Alongside that first byte the caller presents a 2-bit length, a 3-bit addressing-mode code and the contents of the register pair the instruction names. The block keeps these values until the instruction is complete.

When the last byte of an instruction is accepted, the block presents the opcode, a 16-bit operand and the mode code on a result stream, in that same cycle. The operand depends on the mode: a direct memory address, a register number, a register-pair indirect address, or an 8-bit or 16-bit immediate. Multi-byte operands taken from the stream arrive low byte first. A register-pair address is built with the first register of the pair as the high byte. Register storage, memory access and execution belong to other blocks.

Both streams use valid/ready. An opcode byte or middle byte is always accepted (`in_ready` high). The last byte of an instruction is accepted only when `out_ready` is high, so back-pressure on the result stream stalls the input stream at that byte. The caller must hold `in_valid` and the byte steady until the byte is accepted.

Top module: `instr_collector`

## Requirements
- R1: The length is taken from `in_len` together with the opcode byte. Codes 1, 2 and 3 mean that many bytes. Code 0 means one byte. After exactly that many accepted bytes, the next accepted byte is an opcode.
- R2: `out_done` is high for exactly one cycle per instruction: the cycle in which the last byte is accepted (`out_valid` and `out_ready` both high). It is never high while an opcode or middle byte of a longer instruction is accepted.
- R3: Mode code 1 (direct) gives an operand of {third byte, second byte}. The second byte is the low half. A byte that the length leaves out reads as 8'h00.
- R4: Mode code 2 (register indirect) gives an operand of {`rp_first`, `rp_second`}, using the values present when the opcode byte is accepted.
- R5: Mode code 3 (8-bit immediate) gives {8'h00, second byte}. Mode code 4 (16-bit immediate) gives {third byte, second byte}.
- R6: Mode code 0 (register) gives an operand whose bits [2:0] are opcode bits [2:0] and whose other bits are zero. Mode codes 5 to 7 are handled as register mode, and `out_mode` reports them as 0.
- R7: For an opcode or middle byte, `in_ready` is 1. For the last byte, `in_ready` equals `out_ready`. `out_valid` is high only while `in_valid` presents the last byte of an instruction.
- R8: A synchronous reset drops any partly collected instruction. After reset, the next accepted byte is taken as an opcode.
- R9: `out_opcode` is the first byte of the instruction. `in_len`, `in_mode`, `rp_first` and `rp_second` have no effect while a second or third byte is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte is valid |
| in_ready | output | 1 | Block accepts the byte this cycle |
| in_data | input | 8 | Instruction byte |
| in_len | input | 2 | Instruction length, sampled with the opcode |
| in_mode | input | 3 | Addressing-mode code, sampled with the opcode |
| rp_first | input | 8 | First register of the named pair (high address byte) |
| rp_second | input | 8 | Second register of the named pair (low address byte) |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Result consumer is ready |
| out_opcode | output | 8 | Opcode of the finished instruction |
| out_operand | output | 16 | Assembled operand |
| out_mode | output | 3 | Normalised mode code |
| out_done | output | 1 | One-cycle pulse when the instruction completes |

## Verification
Every result is due in the cycle the last byte is accepted, with no added latency. The bench therefore samples `in_ready`, `out_valid`, `out_done` and the result fields shortly before the rising edge at which that byte is taken. For opcode and middle bytes, it checks at the same sample point that `out_done` and `out_valid` are low and `in_ready` is high. While the last byte is held against a low `out_ready`, it checks in every stalled cycle that `in_ready` and `out_done` stay low. The effect of a reset is checked on the first byte presented after it.

// File: rtl/instr_pkg.sv
package instr_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LEN_W  = 2;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned REG_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_REG    = 3'd0,
    AM_DIRECT = 3'd1,
    AM_PAIR   = 3'd2,
    AM_IMM8   = 3'd3,
    AM_IMM16  = 3'd4
  } addr_mode_e;

  function automatic addr_mode_e norm_mode(input logic [MODE_W-1:0] code);
    case (code)
      3'd1:    return AM_DIRECT;
      3'd2:    return AM_PAIR;
      3'd3:    return AM_IMM8;
      3'd4:    return AM_IMM16;
      default: return AM_REG;
    endcase
  endfunction

endpackage

// File: rtl/ibc_len_clamp.sv
module ibc_len_clamp #(
  parameter int unsigned LW = 2
) (
  input  logic [LW-1:0] len_raw,
  output logic [LW-1:0] len_eff
);
  // a zero length code is read as a single-byte instruction
  always_comb begin
    if (len_raw == '0) len_eff = LW'(1);
    else               len_eff = len_raw;
  end
endmodule

// File: rtl/ibc_seq.sv
module ibc_seq #(
  parameter int unsigned W  = 8,
  parameter int unsigned LW = 2,
  parameter int unsigned MW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          last,
  input  logic [W-1:0]  data,
  input  logic [LW-1:0] len_eff,
  input  logic [MW-1:0] mode,
  input  logic [W-1:0]  pair_hi,
  input  logic [W-1:0]  pair_lo,
  output logic [LW-1:0] idx,
  output logic [W-1:0]  held_op,
  output logic [LW-1:0] held_len,
  output logic [MW-1:0] held_mode,
  output logic [W-1:0]  held_hi,
  output logic [W-1:0]  held_lo,
  output logic [W-1:0]  held_b2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      held_op   <= '0;
      held_len  <= LW'(1);
      held_mode <= '0;
      held_hi   <= '0;
      held_lo   <= '0;
      held_b2   <= '0;
    end else if (accept) begin
      if (last) idx <= '0;
      else      idx <= idx + LW'(1);
      if (idx == '0) begin
        held_op   <= data;
        held_len  <= len_eff;
        held_mode <= mode;
        held_hi   <= pair_hi;
        held_lo   <= pair_lo;
      end
      if (idx == LW'(1)) held_b2 <= data;
    end
  end
endmodule

// File: rtl/ibc_operand.sv
module ibc_operand
  import instr_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned RW = 3
) (
  input  addr_mode_e       mode,
  input  logic [W-1:0]     opcode,
  input  logic [W-1:0]     byte2,
  input  logic [W-1:0]     byte3,
  input  logic [W-1:0]     pair_hi,
  input  logic [W-1:0]     pair_lo,
  output logic [2*W-1:0]   operand
);
  localparam int unsigned OW = 2 * W;

  logic [OW-1:0] stream_word;
  logic [OW-1:0] reg_word;

  // byte lanes of the stream word: lane 0 is the earlier (low) byte
  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      if (g == 0) begin : g_lo
        assign stream_word[W-1:0] = byte2;
      end else begin : g_hi
        assign stream_word[OW-1:W] = byte3;
      end
    end
  endgenerate

  assign reg_word = {{(OW-RW){1'b0}}, opcode[RW-1:0]};

  always_comb begin
    case (mode)
      AM_DIRECT: operand = stream_word;
      AM_PAIR:   operand = {pair_hi, pair_lo};
      AM_IMM8:   operand = {{W{1'b0}}, byte2};
      AM_IMM16:  operand = stream_word;
      default:   operand = reg_word;
    endcase
  end
endmodule

// File: rtl/instr_collector.sv
module instr_collector
  import instr_pkg::*;
#(
  parameter int unsigned W  = BYTE_W,
  parameter int unsigned LW = LEN_W,
  parameter int unsigned MW = MODE_W,
  parameter int unsigned RW = REG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_data,
  input  logic [LW-1:0]   in_len,
  input  logic [MW-1:0]   in_mode,
  input  logic [W-1:0]    rp_first,
  input  logic [W-1:0]    rp_second,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_opcode,
  output logic [2*W-1:0]  out_operand,
  output logic [MW-1:0]   out_mode,
  output logic            out_done
);
  logic [LW-1:0] len_eff;
  logic [LW-1:0] idx;
  logic [W-1:0]  held_op, held_hi, held_lo, held_b2;
  logic [LW-1:0] held_len;
  logic [MW-1:0] held_mode;

  logic          at_op;
  logic [LW-1:0] cur_len;
  logic [MW-1:0] cur_mode;
  logic          last_now;
  logic          accept;
  logic [W-1:0]  cur_op, cur_hi, cur_lo, byte2, byte3;
  addr_mode_e    mode_n;

  ibc_len_clamp #(.LW(LW)) u_clamp (
    .len_raw (in_len),
    .len_eff (len_eff)
  );

  assign at_op    = (idx == '0);
  assign cur_len  = at_op ? len_eff : held_len;
  assign cur_mode = at_op ? in_mode : held_mode;
  assign cur_op   = at_op ? in_data : held_op;
  assign cur_hi   = at_op ? rp_first : held_hi;
  assign cur_lo   = at_op ? rp_second : held_lo;
  assign last_now = ({1'b0, idx} + {{LW{1'b0}}, 1'b1}) == {1'b0, cur_len};

  assign in_ready  = last_now ? out_ready : 1'b1;
  assign out_valid = in_valid && last_now;
  assign accept    = in_valid && in_ready;
  assign out_done  = out_valid && out_ready;

  always_comb begin
    byte2 = '0;
    byte3 = '0;
    if (cur_len >= LW'(2)) byte2 = (idx == LW'(1)) ? in_data : held_b2;
    if (cur_len == LW'(3)) byte3 = in_data;
  end

  ibc_seq #(.W(W), .LW(LW), .MW(MW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .last      (last_now),
    .data      (in_data),
    .len_eff   (len_eff),
    .mode      (in_mode),
    .pair_hi   (rp_first),
    .pair_lo   (rp_second),
    .idx       (idx),
    .held_op   (held_op),
    .held_len  (held_len),
    .held_mode (held_mode),
    .held_hi   (held_hi),
    .held_lo   (held_lo),
    .held_b2   (held_b2)
  );

  assign mode_n = norm_mode(cur_mode);

  ibc_operand #(.W(W), .RW(RW)) u_opnd (
    .mode    (mode_n),
    .opcode  (cur_op),
    .byte2   (byte2),
    .byte3   (byte3),
    .pair_hi (cur_hi),
    .pair_lo (cur_lo),
    .operand (out_operand)
  );

  assign out_opcode = cur_op;
  assign out_mode   = mode_n;
endmodule

// File: rtl/instr_collector_chk.sv
module instr_collector_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned LW = 2,
  parameter int unsigned MW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic           out_done,
  input logic [MW-1:0]  out_mode,
  input logic [2*W-1:0] out_operand,
  input logic [LW-1:0]  idx
);
  // R2: a done pulse only on an accepted last byte
  p_done_fire_r2: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (out_valid && in_valid && in_ready));

  // R5: 8-bit immediate keeps the upper operand byte at zero
  p_imm8_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == 3'd3) |-> (out_operand[2*W-1:W] == '0));

  // R6: only legal mode codes reach the result
  p_mode_legal_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mode <= 3'd4));

  // R7: a stalled result holds back the input stream
  p_backpress_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: without a pending last byte the input is always accepted
  p_mid_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !out_valid) |-> in_ready);

  // R8: leaving reset the next byte is an opcode
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (idx == '0));

  // R1: position never exceeds the third byte
  p_idx_range_r1: assert property (@(posedge clk) disable iff (rst)
    idx <= LW'(2));
endmodule

bind instr_collector instr_collector_chk #(.W(W), .LW(LW), .MW(MW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_done    (out_done),
  .out_mode    (out_mode),
  .out_operand (out_operand),
  .idx         (idx)
);

// File: tb/test_instr_collector.sv
`timescale 1ns/100ps
module test_instr_collector;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready, out_done;
  logic [7:0]  in_data, rp_first, rp_second, out_opcode;
  logic [1:0]  in_len;
  logic [2:0]  in_mode, out_mode;
  logic [15:0] out_operand;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  instr_collector i_instr_collector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_len(in_len), .in_mode(in_mode),
    .rp_first(rp_first), .rp_second(rp_second), .out_valid(out_valid),
    .out_ready(out_ready), .out_opcode(out_opcode), .out_operand(out_operand),
    .out_mode(out_mode), .out_done(out_done)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_operand(input logic [2:0] m, input logic [7:0] op,
      input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] f, input logic [7:0] s);
    case (m)
      3'd1: return {b3, b2};
      3'd2: return {f, s};
      3'd3: return {8'h00, b2};
      3'd4: return {b3, b2};
      default: return {13'd0, op[2:0]};
    endcase
  endfunction

  function automatic logic [2:0] exp_mode(input logic [2:0] m);
    return (m > 3'd4) ? 3'd0 : m;
  endfunction

  // present one byte until accepted; checks are sampled 0.5 ns before the edge
  task automatic put_byte(input logic [7:0] d, input logic [1:0] l, input logic [2:0] m,
      input logic [7:0] f, input logic [7:0] s, input bit last,
      input logic [7:0] eop, input logic [15:0] eopd, input logic [2:0] emd, input bit force_stall);
    bit done_flag = 0;
    int stalls = 0;
    while (!done_flag) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_len = l; in_mode = m;
      rp_first = f; rp_second = s;
      if (force_stall && stalls < 2) out_ready = 1'b0;
      else out_ready = ($urandom % 4) != 0;
      #2.0;
      if (last && !out_ready) begin
        stalls++;
        chk(in_ready == 1'b0, "R7 last-byte stall in_ready", 16'(in_ready), 16'h0);
        chk(out_done == 1'b0, "R2 no done while stalled", 16'(out_done), 16'h0);
      end else if (!last) begin
        chk(in_ready == 1'b1, "R7 middle/opcode in_ready", 16'(in_ready), 16'h1);
        chk(out_done == 1'b0 && out_valid == 1'b0, "R2 no done before last byte",
            {14'd0, out_valid, out_done}, 16'h0);
        done_flag = 1;
      end else begin
        chk(out_done == 1'b1, "R2 done on last byte", 16'(out_done), 16'h1);
        chk(out_opcode == eop, "R9 opcode", 16'(out_opcode), 16'(eop));
        chk(out_operand == eopd, "R3/R4/R5/R6 operand", out_operand, eopd);
        chk(out_mode == emd, "R6 mode code", 16'(out_mode), 16'(emd));
        done_flag = 1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 8'($urandom);
  endtask

  task automatic send_instr(input logic [7:0] op, input logic [1:0] len, input logic [2:0] m,
      input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] f, input logic [7:0] s,
      input bit stall);
    int eff = (len == 2'd0) ? 1 : int'(len);
    logic [7:0] e2 = (eff >= 2) ? b2 : 8'h00;
    logic [7:0] e3 = (eff == 3) ? b3 : 8'h00;
    logic [15:0] eo = exp_operand(m, op, e2, e3, f, s);
    logic [2:0] em = exp_mode(m);
    put_byte(op, len, m, f, s, eff == 1, op, eo, em, stall);
    // R9: later bytes carry random length, mode and pair values that must be ignored
    if (eff >= 2) put_byte(b2, 2'($urandom), 3'($urandom), 8'($urandom), 8'($urandom),
                           eff == 2, op, eo, em, stall);
    if (eff == 3) put_byte(b3, 2'($urandom), 3'($urandom), 8'($urandom), 8'($urandom),
                           1'b1, op, eo, em, stall);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; in_valid = 1'b0; in_data = 8'h00; in_len = 2'd0; in_mode = 3'd0;
    rp_first = 8'h00; rp_second = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2.0;
    chk(out_valid == 1'b0 && out_done == 1'b0, "R8 reset idle outputs",
        {14'd0, out_valid, out_done}, 16'h0);
    chk(in_ready == 1'b1, "R8 reset in_ready", 16'(in_ready), 16'h1);

    // directed corners
    send_instr(8'hC3, 2'd3, 3'd1, 8'h34, 8'h12, 8'h00, 8'h00, 1'b0); // R3 direct
    send_instr(8'h3A, 2'd2, 3'd1, 8'h9A, 8'hEE, 8'h00, 8'h00, 1'b0); // R3 missing high byte
    send_instr(8'h7E, 2'd1, 3'd2, 8'h00, 8'h00, 8'hAB, 8'hCD, 1'b0); // R4 pair indirect
    send_instr(8'h0A, 2'd2, 3'd2, 8'h55, 8'h00, 8'h81, 8'h18, 1'b0); // R4 captured at opcode
    send_instr(8'h3E, 2'd2, 3'd3, 8'h5A, 8'h00, 8'h00, 8'h00, 1'b1); // R5 imm8 with stall
    send_instr(8'h21, 2'd3, 3'd4, 8'h78, 8'h56, 8'h00, 8'h00, 1'b1); // R5 imm16 with stall
    send_instr(8'h47, 2'd0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0); // R1 len 0 -> 1, R6
    send_instr(8'hFD, 2'd1, 3'd7, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0); // R6 mode 7 as register

    // R8: reset in the middle of a three-byte instruction
    put_byte(8'hCD, 2'd3, 3'd1, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0, 3'd0, 1'b0);
    put_byte(8'h11, 2'd0, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0, 3'd0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send_instr(8'h05, 2'd1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0); // R8 next byte is opcode

    // constrained random
    for (int n = 0; n < 400; n++) begin
      send_instr(8'($urandom), 2'($urandom), 3'($urandom), 8'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom), ($urandom % 8) == 0);
      if (($urandom % 3) == 0) begin
        @(negedge clk);
        #2.0;
        chk(out_valid == 1'b0 && out_done == 1'b0, "R7 idle without valid",
            {14'd0, out_valid, out_done}, 16'h0);
      end
    end

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule